// File: doc/BRIEF.md
# Triple-Redundant Step Sequencer with Majority Voting

This block is a small step sequencer built three times over. The three copies run in lockstep and take the same command inputs. A bitwise majority voter combines their state registers every cycle. The outputs are decoded from the voted state, so a single upset copy never reaches them.

The sequencer waits in an idle code until it sees a start command. It then walks through `NUM_STEPS` numbered steps, one step per advance command. After the last step it enters a done code for one cycle and then returns to idle. An abort command sends it back to idle from any step.

When one copy disagrees with the other two, the block flags that copy for one cycle. On the next clock edge the copy is reloaded with the next state computed from the voted state, so it rejoins the pair. When all three copies hold pairwise different values, there is no majority. The block then raises a fatal flag, blanks the outputs and returns every copy to idle. A test port can overwrite any copy with an arbitrary code so that upsets can be provoked.

Top module: `tmr_sequencer`

## Requirements
- R1: Reset is synchronous and active-low. While `rst_n` is low at a clock edge, every copy loads the idle code 0 and the corruption port is ignored. After that edge, `busy_o`, `step_o`, `done_o`, `fault_copy_o` and `fault_fatal_o` are all zero.
- R2: The codes are as follows: idle is 0, step k is k (1..NUM_STEPS), and done is NUM_STEPS+1. The transitions are:
  - idle with `start_i` goes to step 1;
  - step k with `advance_i` goes to step k+1;
  - step NUM_STEPS with `advance_i` goes to done;
  - done goes to idle on the next edge whatever the inputs.
- R3: In any step, `abort_i` returns the sequencer to idle and wins over `advance_i`. In idle, `advance_i` and `abort_i` have no effect. While a step is active, `start_i` has no effect.
- R4: The outputs are decoded from the voted state:
  - `busy_o` is high in steps 1..NUM_STEPS;
  - `step_o` is one-hot, with bit k-1 set in step k;
  - `done_o` is high in the done code;
  - a voted code above NUM_STEPS+1 (illegal) drives all three outputs to zero.
- R5: The voted state is the bitwise majority of the three copy registers.
- R6: `fault_copy_o[i]` is high in each cycle where copy i differs from the voted state while the other two agree. At most one bit is ever set.
- R7: A flagged copy loads, at the next edge, the next state computed from the voted state and the current commands. This holds even when the sequencer advances in the same cycle. The flag then clears unless a new corruption arrives.
- R8: When the three copies are pairwise different, `fault_fatal_o` is high for that cycle and `fault_copy_o` is zero. In that cycle `busy_o`, `step_o` and `done_o` are zero, and every copy holds idle after the next edge.
- R9: `corrupt_en_i[i]` makes copy i load `corrupt_state_i[i*STATE_W +: STATE_W]` at the next edge. This takes priority over repair and over the fatal return to idle, but not over reset.
- R10: While one copy is being repaired, `busy_o`, `step_o` and `done_o` are identical to those of a fault-free run given the same commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start the sequence from idle |
| advance_i | input | 1 | Move to the next step |
| abort_i | input | 1 | Return to idle from any step |
| corrupt_en_i | input | 3 | Per-copy overwrite enable (test port) |
| corrupt_state_i | input | 3*STATE_W | Overwrite codes, copy i in bits i*STATE_W upward |
| busy_o | output | 1 | A step is active |
| step_o | output | NUM_STEPS | One-hot current step |
| done_o | output | 1 | Sequence finished (one cycle) |
| fault_copy_o | output | 3 | Per-copy disagreement pulse |
| fault_fatal_o | output | 1 | No two copies agree |

## Verification
Two functions can fall in the same cycle: the repair of a flagged copy and a normal sequencer transition. A third case joins them: a fresh corruption of a different copy arriving on the same edge as a repair. The bench provokes each case with the test port. It corrupts one copy, then issues an advance on the repair cycle. Elsewhere it corrupts a second copy on the repair edge. Each case is judged against an independent per-copy model: the repaired copy must land on the voted next step rather than the voted current step, and the outputs must track a fault-free run throughout.

// File: rtl/tmr_seq_pkg.sv
// Package: shared constants and types for the triple-redundant sequencer.
// Assumes: exactly three copies; the command struct is shared by all copies.
package tmr_seq_pkg;

    // Number of redundant copies; the voter is written for three.
    localparam int TMR_COPIES = 3;

    // Command bundle fed identically to every copy.
    typedef struct packed {
        logic start;
        logic advance;
        logic abort;
    } seq_cmd_t;

endpackage

// File: rtl/seq_next_logic.sv
// Module: next-state function of one sequencer copy.
// What it does: maps a current code and the commands to the next code.
// Codes: 0 idle, 1..NUM_STEPS steps, NUM_STEPS+1 done, above that illegal.
// Assumes: purely combinational; illegal and done codes both lead to idle.
module seq_next_logic
    import tmr_seq_pkg::*;
#(
    parameter int NUM_STEPS = 5,
    parameter int STATE_W   = $clog2(NUM_STEPS + 2)
) (
    input  logic [STATE_W-1:0] cur_state,
    input  seq_cmd_t           cmd,
    output logic [STATE_W-1:0] nxt_state
);

    localparam logic [STATE_W-1:0] IDLE_CODE = '0;
    localparam logic [STATE_W-1:0] LAST_STEP = STATE_W'(NUM_STEPS);
    localparam logic [STATE_W-1:0] ONE_CODE  = STATE_W'(1);

    // Transition table: start from idle, advance/abort in steps, done/illegal to idle.
    always_comb begin
        nxt_state = IDLE_CODE;
        if (cur_state == IDLE_CODE) begin
            nxt_state = cmd.start ? ONE_CODE : IDLE_CODE;
        end else if (cur_state <= LAST_STEP) begin
            if (cmd.abort) begin
                nxt_state = IDLE_CODE;
            end else if (cmd.advance) begin
                nxt_state = cur_state + ONE_CODE;
            end else begin
                nxt_state = cur_state;
            end
        end else begin
            nxt_state = IDLE_CODE;
        end
    end

endmodule

// File: rtl/tmr_seq_copy.sv
// Module: one redundant copy of the sequencer with its own state register.
// What it does: advances on its own next-state logic. When flagged, it reloads
// the voted next state. On a fatal disagreement it returns to idle. A test
// overwrite can replace its state.
// Assumes: repair and fatal come from the voter for the current cycle.
module tmr_seq_copy
    import tmr_seq_pkg::*;
#(
    parameter int NUM_STEPS = 5,
    parameter int STATE_W   = $clog2(NUM_STEPS + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_cmd_t           cmd,
    input  logic [STATE_W-1:0] voted_next,
    input  logic               repair,
    input  logic               fatal,
    input  logic               corrupt_en,
    input  logic [STATE_W-1:0] corrupt_val,
    output logic [STATE_W-1:0] state_q
);

    localparam logic [STATE_W-1:0] IDLE_CODE = '0;

    logic [STATE_W-1:0] own_next;

    seq_next_logic #(
        .NUM_STEPS (NUM_STEPS),
        .STATE_W   (STATE_W)
    ) u_next (
        .cur_state (state_q),
        .cmd       (cmd),
        .nxt_state (own_next)
    );

    // State register: reset, then overwrite, then fatal, then repair, then own step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IDLE_CODE;
        end else if (corrupt_en) begin
            state_q <= corrupt_val;
        end else if (fatal) begin
            state_q <= IDLE_CODE;
        end else if (repair) begin
            state_q <= voted_next;
        end else begin
            state_q <= own_next;
        end
    end

    // R9
    corrupt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        corrupt_en |=> state_q == $past(corrupt_val));

    // R7
    repair_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repair && !corrupt_en && !fatal) |=> state_q == $past(voted_next));

    // R8
    fatal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal && !corrupt_en) |=> state_q == IDLE_CODE);

endmodule

// File: rtl/tmr_seq_voter.sv
// Module: bitwise majority voter over the three copy registers.
// What it does: forms the voted state and flags the single disagreeing copy.
// It raises fatal when no two copies agree.
// Assumes: exactly three copies.
module tmr_seq_voter
    import tmr_seq_pkg::*;
#(
    parameter int STATE_W = 3
) (
    input  logic [TMR_COPIES-1:0][STATE_W-1:0] copy_state,
    output logic [STATE_W-1:0]                 voted,
    output logic [TMR_COPIES-1:0]              mismatch,
    output logic                               fatal
);

    logic [STATE_W-1:0] st_a, st_b, st_c;

    // Name the three inputs for readability.
    always_comb begin
        st_a = copy_state[0];
        st_b = copy_state[1];
        st_c = copy_state[2];
    end

    // Per-bit two-of-three majority.
    always_comb begin
        voted = (st_a & st_b) | (st_a & st_c) | (st_b & st_c);
    end

    // No pair agrees: there is no trustworthy majority.
    always_comb begin
        fatal = (st_a != st_b) && (st_b != st_c) && (st_a != st_c);
    end

    // Flag each copy that departs from a real majority.
    for (genvar g = 0; g < TMR_COPIES; g++) begin : g_flag
        always_comb begin
            mismatch[g] = (copy_state[g] != voted) && !fatal;
        end
    end

endmodule

// File: rtl/tmr_seq_decode.sv
// Module: output decoder driven only by the voted state.
// What it does: produces busy, the one-hot step vector and done. It blanks all
// of them for an illegal code or a fatal disagreement.
// Assumes: codes 0 idle, 1..NUM_STEPS steps, NUM_STEPS+1 done.
module tmr_seq_decode #(
    parameter int NUM_STEPS = 5,
    parameter int STATE_W   = $clog2(NUM_STEPS + 2)
) (
    input  logic [STATE_W-1:0] voted,
    input  logic               fatal,
    output logic               busy,
    output logic [NUM_STEPS-1:0] step,
    output logic               done
);

    localparam logic [STATE_W-1:0] IDLE_CODE = '0;
    localparam logic [STATE_W-1:0] LAST_STEP = STATE_W'(NUM_STEPS);
    localparam logic [STATE_W-1:0] DONE_CODE = STATE_W'(NUM_STEPS + 1);

    // Busy and done from the voted code, forced low on fatal.
    always_comb begin
        busy = !fatal && (voted != IDLE_CODE) && (voted <= LAST_STEP);
        done = !fatal && (voted == DONE_CODE);
    end

    // One-hot step lines, one per step code.
    for (genvar k = 0; k < NUM_STEPS; k++) begin : g_step
        always_comb begin
            step[k] = busy && (voted == STATE_W'(k + 1));
        end
    end

endmodule

// File: rtl/tmr_sequencer.sv
// Module: triple-redundant step sequencer (top).
// What it does: runs three sequencer copies in lockstep. It votes their state
// each cycle and decodes the outputs from the vote. It resynchronises a lone
// disagreeing copy and recovers to idle when no majority exists.
// Assumes: the test overwrite port is held low in normal operation.
module tmr_sequencer
    import tmr_seq_pkg::*;
#(
    parameter  int NUM_STEPS = 5,
    localparam int STATE_W   = $clog2(NUM_STEPS + 2)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          advance_i,
    input  logic                          abort_i,
    input  logic [TMR_COPIES-1:0]         corrupt_en_i,
    input  logic [TMR_COPIES*STATE_W-1:0] corrupt_state_i,
    output logic                          busy_o,
    output logic [NUM_STEPS-1:0]          step_o,
    output logic                          done_o,
    output logic [TMR_COPIES-1:0]         fault_copy_o,
    output logic                          fault_fatal_o
);

    seq_cmd_t                          cmd;
    logic [TMR_COPIES-1:0][STATE_W-1:0] copy_state;
    logic [STATE_W-1:0]                voted;
    logic [STATE_W-1:0]                voted_next;
    logic [TMR_COPIES-1:0]             mismatch;
    logic                              fatal;

    // Bundle the command pins for all copies.
    always_comb begin
        cmd.start   = start_i;
        cmd.advance = advance_i;
        cmd.abort   = abort_i;
    end

    // Three identical copies, each with its own overwrite slice.
    for (genvar g = 0; g < TMR_COPIES; g++) begin : g_copy
        tmr_seq_copy #(
            .NUM_STEPS (NUM_STEPS),
            .STATE_W   (STATE_W)
        ) u_copy (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd         (cmd),
            .voted_next  (voted_next),
            .repair      (mismatch[g]),
            .fatal       (fatal),
            .corrupt_en  (corrupt_en_i[g]),
            .corrupt_val (corrupt_state_i[g*STATE_W +: STATE_W]),
            .state_q     (copy_state[g])
        );
    end

    tmr_seq_voter #(
        .STATE_W (STATE_W)
    ) u_voter (
        .copy_state (copy_state),
        .voted      (voted),
        .mismatch   (mismatch),
        .fatal      (fatal)
    );

    // Next state of the voted code, used to reload a flagged copy.
    seq_next_logic #(
        .NUM_STEPS (NUM_STEPS),
        .STATE_W   (STATE_W)
    ) u_voted_next (
        .cur_state (voted),
        .cmd       (cmd),
        .nxt_state (voted_next)
    );

    tmr_seq_decode #(
        .NUM_STEPS (NUM_STEPS),
        .STATE_W   (STATE_W)
    ) u_decode (
        .voted (voted),
        .fatal (fatal),
        .busy  (busy_o),
        .step  (step_o),
        .done  (done_o)
    );

    // Fault indicators straight from the voter.
    always_comb begin
        fault_copy_o  = mismatch;
        fault_fatal_o = fatal;
    end

    // R6
    single_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_copy_o) && !(fault_fatal_o && (fault_copy_o != '0)));

    // R7
    copy_rejoin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_copy_o != '0) && (corrupt_en_i == '0)) |=> (fault_copy_o == '0) && !fault_fatal_o);

    // R2
    step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && advance_i && !abort_i && !step_o[NUM_STEPS-1] && !fault_fatal_o
         && (corrupt_en_i == '0)) |=> step_o == ($past(step_o) << 1));

    // R3
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && abort_i && !fault_fatal_o && (corrupt_en_i == '0)) |=> !busy_o && !done_o);

    // R8
    fatal_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_fatal_o && (corrupt_en_i == '0)) |=> !fault_fatal_o && (fault_copy_o == '0) && !busy_o);

endmodule

// File: tb/tmr_sequencer_test.sv
// Bench: scoreboard. The driver updates a per-copy model at each edge and
// queues the expected outputs; the monitor compares them 3 ns after the edge.
module tmr_sequencer_test;

    localparam int N = 5;
    localparam int W = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0, advance_i = 1'b0, abort_i = 1'b0;
    logic [2:0]     corrupt_en_i = '0;
    logic [3*W-1:0] corrupt_state_i = '0;
    logic           busy_o, done_o, fault_fatal_o;
    logic [N-1:0]   step_o;
    logic [2:0]     fault_copy_o;

    tmr_sequencer uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .advance_i       (advance_i),
        .abort_i         (abort_i),
        .corrupt_en_i    (corrupt_en_i),
        .corrupt_state_i (corrupt_state_i),
        .busy_o          (busy_o),
        .step_o          (step_o),
        .done_o          (done_o),
        .fault_copy_o    (fault_copy_o),
        .fault_fatal_o   (fault_fatal_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [N+5:0] outs;  // {busy, step, done, fault_copy, fatal}
        string        req;
    } exp_t;

    exp_t       sb_q[$];
    int         checks = 0;
    int         fails = 0;
    bit         finished = 0;
    logic [W-1:0] mdl [3];

    function automatic logic [W-1:0] ref_next(logic [W-1:0] s, logic st, logic ad, logic ab);
        if (s == 0) return st ? W'(1) : W'(0);
        if (s <= W'(N)) return ab ? W'(0) : (ad ? s + W'(1) : s);
        return W'(0);
    endfunction

    function automatic logic [W-1:0] maj(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Push the outputs expected for the current model state.
    task automatic push_expect(input string req);
        logic [W-1:0] v;
        logic         fat, bsy, dn;
        logic [N-1:0] stp;
        logic [2:0]   fc;
        exp_t         e;
        v   = maj(mdl[0], mdl[1], mdl[2]);
        fat = (mdl[0] != mdl[1]) && (mdl[1] != mdl[2]) && (mdl[0] != mdl[2]);
        for (int i = 0; i < 3; i++) fc[i] = (mdl[i] != v) && !fat;
        bsy = !fat && (v >= 1) && (v <= W'(N));
        stp = bsy ? N'(1) << (v - 1) : '0;
        dn  = !fat && (v == W'(N + 1));
        e.outs = {bsy, stp, dn, fc, fat};
        e.req  = req;
        sb_q.push_back(e);
    endtask

    // Drive one cycle, advance the model at the edge, queue the result.
    task automatic tick(input logic st, input logic ad, input logic ab,
                        input logic [2:0] ce, input logic [3*W-1:0] cv, input string req);
        logic [W-1:0] v, vn;
        logic [W-1:0] nx [3];
        logic         fat;
        start_i = st; advance_i = ad; abort_i = ab;
        corrupt_en_i = ce; corrupt_state_i = cv;
        @(posedge clk);
        v   = maj(mdl[0], mdl[1], mdl[2]);
        fat = (mdl[0] != mdl[1]) && (mdl[1] != mdl[2]) && (mdl[0] != mdl[2]);
        vn  = ref_next(v, st, ad, ab);
        for (int i = 0; i < 3; i++) begin
            if (!rst_n)          nx[i] = '0;
            else if (ce[i])      nx[i] = cv[i*W +: W];
            else if (fat)        nx[i] = '0;
            else if (mdl[i] != v) nx[i] = vn;
            else                 nx[i] = ref_next(mdl[i], st, ad, ab);
        end
        for (int i = 0; i < 3; i++) mdl[i] = nx[i];
        push_expect(req);
        @(negedge clk);
    endtask

    task automatic cmd(input logic st, input logic ad, input logic ab, input string req);
        tick(st, ad, ab, 3'b000, '0, req);
    endtask

    // Monitor: compare queued expectations away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (sb_q.size() > 0) begin
                exp_t e;
                logic [N+5:0] act;
                e   = sb_q.pop_front();
                act = {busy_o, step_o, done_o, fault_copy_o, fault_fatal_o};
                checks++;
                if (act !== e.outs) begin
                    fails++;
                    $display("FAIL %s: {busy,step,done,fault_copy,fatal} actual %b expected %b",
                             e.req, act, e.outs);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset, including an overwrite attempt that must be ignored
        rst_n = 1'b0;
        cmd(0, 0, 0, "R1");
        tick(0, 0, 0, 3'b111, 9'b101_011_110, "R1");
        rst_n = 1'b1;
        cmd(0, 0, 0, "R1");

        // R3: advance and abort in idle have no effect
        cmd(0, 1, 0, "R3");
        cmd(0, 0, 1, "R3");

        // R2 / R4: full walk to done and back to idle
        cmd(1, 0, 0, "R2");
        for (int k = 0; k < N; k++) cmd(0, 1, 0, "R2_R4");
        cmd(0, 0, 0, "R2");
        cmd(0, 0, 0, "R2");

        // R3: start ignored while running, abort beats advance
        cmd(1, 0, 0, "R3");
        cmd(0, 1, 0, "R3");
        cmd(1, 0, 0, "R3");
        cmd(0, 1, 1, "R3");

        // R5 / R6 / R7 / R10: single upset, repaired while advancing
        cmd(1, 0, 0, "R10");
        tick(0, 0, 0, 3'b010, 9'(4 << W), "R6");
        cmd(0, 1, 0, "R7_R10");
        cmd(0, 1, 0, "R7");

        // R7 / R9: new upset on another copy on the repair edge
        tick(0, 0, 0, 3'b001, 9'(5), "R9");
        tick(0, 1, 0, 3'b100, 9'(6 << (2*W)), "R7_R9");
        cmd(0, 0, 0, "R7");
        cmd(0, 0, 0, "R10");

        // R8: three-way disagreement
        tick(0, 0, 0, 3'b101, 9'(1 | (2 << (2*W))), "R8");
        cmd(0, 0, 0, "R8");
        cmd(0, 0, 0, "R8");

        // R4 / R5: two copies upset to the same illegal code
        cmd(1, 0, 0, "R5");
        tick(0, 0, 0, 3'b011, 9'(7 | (7 << W)), "R4_R5");
        cmd(0, 0, 0, "R4");
        cmd(0, 0, 0, "R5");

        // R9: overwrite wins over fatal recovery
        cmd(1, 1, 0, "R9");
        tick(0, 0, 0, 3'b110, 9'((3 << W) | (4 << (2*W))), "R9");
        tick(0, 0, 0, 3'b111, 9'(3 | (3 << W) | (3 << (2*W))), "R9");
        cmd(0, 1, 0, "R9");
        cmd(0, 0, 1, "R9");

        @(posedge clk);
        #5;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule